// File: doc/BRIEF.md
# NAND Flash Command Busy Tracker

This block is a synthesizable model of the command front end of a NAND flash device whose host interface is the clockless SDR bus. The host writes command and address bytes on an 8-bit bus and strobes each one with the active-low write enable. A command-latch enable or an address-latch enable, whichever is high, marks the kind of byte. The block captures each byte on the rising edge of that strobe. It then moves the byte into the domain of a free-running internal clock, where a small sequencer decodes the commands it knows.

Two commands start a timed internal operation. Reset is the single command 0xFF. Block erase is 0x60, followed by the row-address bytes and then the confirm command 0xD0. While an operation runs, the open-drain style ready/busy output is held low. It rises again when a cycle counter driven by the internal clock expires. Bit 6 of the status byte always mirrors the ready/busy output. The host reads the status byte on the same bus by writing 0x70 and then pulling read enable low.

Top module: `nand_busy_tracker`

## Requirements
- R1: A byte is captured only on the rising edge of `we_ni`, and only when exactly one of `cle_i` (command) and `ale_i` (address) is high. Holding `we_ni` low has no effect. A strobe with both enables high, or with neither high, has no effect.
- R2: Command 0xFF drives `rb_no` low for exactly `RESET_CYCLES` internal clock cycles. The low phase starts a few cycles after the strobe.
- R3: The sequence command 0x60, then `ROW_BYTES` address bytes, then command 0xD0 drives `rb_no` low for exactly `ERASE_CYCLES` cycles.
- R4: An erase setup is abandoned, and a later 0xD0 starts nothing, in three cases: another command arrives before the sequence is complete, fewer than `ROW_BYTES` address bytes arrive before 0xD0, or an extra address byte arrives. A repeated 0x60 restarts the setup.
- R5: Command 0xFF is accepted while busy. It ends the erase in progress and restarts the busy time with `RESET_CYCLES`.
- R6: While busy, every command other than 0xFF is ignored. A complete erase sequence sent during a busy period neither extends that period nor leaves a pending erase behind.
- R7: After command 0x70, `io_oe_o` is high and `io_o` carries the status byte exactly while `re_ni` is low. Any later command ends status mode, so `io_oe_o` stays low.
- R8: In the status byte, bit 6 equals `rb_no` (1 = ready, 0 = busy). Every other bit equals the same bit of `STATUS_FIXED`.
- R9: After `rst_ni` is released, `rb_no` is high and `io_oe_o` is low.
- R10: Address bytes that arrive with no erase setup open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running internal clock that times operations |
| rst_ni | input | 1 | Active-low power-on reset for both domains |
| we_ni | input | 1 | Active-low write strobe; the byte is captured on its rising edge |
| re_ni | input | 1 | Active-low read strobe for the status byte |
| cle_i | input | 1 | Marks the strobed byte as a command |
| ale_i | input | 1 | Marks the strobed byte as an address |
| io_i | input | 8 | Bus value from the host |
| io_o | output | 8 | Status byte driven toward the host |
| io_oe_o | output | 1 | Output enable for `io_o` |
| rb_no | output | 1 | Ready/busy, low while an operation runs |

## Verification
The bench builds the block with `RESET_CYCLES` = 40 and `ERASE_CYCLES` = 400. These values keep every timed operation to a few hundred cycles. They also put a ten-to-one gap between the two durations, so a reset that fails to cut an erase short stands out at once in the measured low time. `STATUS_FIXED` = 0xE5 has mixed ones and zeros around bit 6, so a status read catches a fixed bit or a mirror bit that is stuck or shifted. The defaults are kept for `ROW_BYTES` = 3 and `SYNC_STAGES` = 2, which makes the short-address and extra-address abort cases differ by one byte from a valid erase.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

   localparam int BUS_W = 8;

   localparam logic [BUS_W-1:0] OP_RESET       = 8'hFF;
   localparam logic [BUS_W-1:0] OP_ERASE_SETUP = 8'h60;
   localparam logic [BUS_W-1:0] OP_ERASE_GO    = 8'hD0;
   localparam logic [BUS_W-1:0] OP_STATUS      = 8'h70;

   localparam int RB_BIT = 6;

   typedef struct packed {
      logic             is_addr;
      logic [BUS_W-1:0] value;
   } bus_byte_t;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_ROW,
      SEQ_CONFIRM
   } seq_state_e;

endpackage

// File: rtl/nbt_strobe_capture.sv
module nbt_strobe_capture
   import nbt_pkg::*;
(
   input  logic             rst_ni,
   input  logic             we_ni,
   input  logic             cle_i,
   input  logic             ale_i,
   input  logic [BUS_W-1:0] io_i,
   output bus_byte_t        byte_o,
   output logic             toggle_o,
   output logic             status_sel_o
);

   logic take_w;
   logic is_cmd_w;

   assign take_w   = cle_i ^ ale_i;
   assign is_cmd_w = cle_i & ~ale_i;

   // Write-strobe domain: the rising edge of we_ni is the only clock here.
   always_ff @(posedge we_ni or negedge rst_ni) begin
      if (!rst_ni) begin
         byte_o   <= '0;
         toggle_o <= 1'b0;
      end else if (take_w) begin
         byte_o.is_addr <= ale_i;
         byte_o.value   <= io_i;
         toggle_o       <= ~toggle_o;
      end
   end

   // Status mode is opened by the status command and closed by any other command.
   always_ff @(posedge we_ni or negedge rst_ni) begin
      if (!rst_ni) begin
         status_sel_o <= 1'b0;
      end else if (is_cmd_w) begin
         status_sel_o <= (io_i == OP_STATUS);
      end
   end

endmodule

// File: rtl/nbt_sync.sv
module nbt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("nbt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= 1'b0;
            else         chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= 1'b0;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/nbt_op_ctrl.sv
module nbt_op_ctrl
   import nbt_pkg::*;
#(
   parameter int ROW_BYTES    = 3,
   parameter int RESET_CYCLES = 5000,
   parameter int ERASE_CYCLES = 300000
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      evt_valid_i,
   input  bus_byte_t evt_i,
   output logic      busy_o
);

   localparam int MAX_DUR = (RESET_CYCLES > ERASE_CYCLES) ? RESET_CYCLES : ERASE_CYCLES;
   localparam int CNT_W   = $clog2(MAX_DUR + 1);
   localparam int ROW_W   = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;

   localparam logic [CNT_W-1:0] RESET_LOAD = CNT_W'(RESET_CYCLES - 1);
   localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);
   localparam logic [ROW_W-1:0] ROW_LAST   = ROW_W'(ROW_BYTES - 1);

   if (RESET_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_dur
      $error("nbt_op_ctrl: durations must be at least one cycle");
   end
   if (ROW_BYTES < 1) begin : g_bad_row
      $error("nbt_op_ctrl: ROW_BYTES must be at least 1");
   end

   seq_state_e       seq_q;
   logic [ROW_W-1:0] row_cnt_q;
   logic [CNT_W-1:0] remain_q;
   logic             busy_q;

   logic is_cmd_w;
   logic is_reset_w;
   logic is_setup_w;
   logic is_go_w;

   assign is_cmd_w   = evt_valid_i & ~evt_i.is_addr;
   assign is_reset_w = is_cmd_w & (evt_i.value == OP_RESET);
   assign is_setup_w = is_cmd_w & (evt_i.value == OP_ERASE_SETUP);
   assign is_go_w    = is_cmd_w & (evt_i.value == OP_ERASE_GO);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seq_q     <= SEQ_IDLE;
         row_cnt_q <= '0;
         remain_q  <= '0;
         busy_q    <= 1'b0;
      end else begin
         // Operation timer: the load below wins over the release.
         if (busy_q) begin
            if (remain_q == '0) busy_q   <= 1'b0;
            else                remain_q <= remain_q - 1'b1;
         end

         if (is_reset_w) begin
            busy_q   <= 1'b1;
            remain_q <= RESET_LOAD;
            seq_q    <= SEQ_IDLE;
         end else if (evt_valid_i && !busy_q) begin
            unique case (seq_q)
               SEQ_IDLE: begin
                  if (is_setup_w) begin
                     seq_q     <= SEQ_ROW;
                     row_cnt_q <= '0;
                  end
               end
               SEQ_ROW: begin
                  if (evt_i.is_addr) begin
                     if (row_cnt_q == ROW_LAST) seq_q <= SEQ_CONFIRM;
                     else                       row_cnt_q <= row_cnt_q + 1'b1;
                  end else if (is_setup_w) begin
                     row_cnt_q <= '0;
                  end else begin
                     seq_q <= SEQ_IDLE;
                  end
               end
               SEQ_CONFIRM: begin
                  if (is_go_w) begin
                     busy_q   <= 1'b1;
                     remain_q <= ERASE_LOAD;
                     seq_q    <= SEQ_IDLE;
                  end else if (is_setup_w) begin
                     seq_q     <= SEQ_ROW;
                     row_cnt_q <= '0;
                  end else begin
                     seq_q <= SEQ_IDLE;
                  end
               end
               default: seq_q <= SEQ_IDLE;
            endcase
         end
      end
   end

   assign busy_o = busy_q;

endmodule

// File: rtl/nand_busy_tracker.sv
module nand_busy_tracker
   import nbt_pkg::*;
#(
   parameter int               ROW_BYTES    = 3,
   parameter int               RESET_CYCLES = 5000,
   parameter int               ERASE_CYCLES = 300000,
   parameter int               SYNC_STAGES  = 2,
   parameter logic [BUS_W-1:0] STATUS_FIXED = 8'hE0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_ni,
   input  logic             re_ni,
   input  logic             cle_i,
   input  logic             ale_i,
   input  logic [BUS_W-1:0] io_i,
   output logic [BUS_W-1:0] io_o,
   output logic             io_oe_o,
   output logic             rb_no
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("nand_busy_tracker: SYNC_STAGES must be at least 2");
   end

   bus_byte_t        cap_byte;
   logic             cap_toggle;
   logic             status_sel;
   logic             toggle_sync;
   logic             toggle_seen_q;
   logic             evt_valid;
   logic             busy;
   logic [BUS_W-1:0] status_byte;

   nbt_strobe_capture u_capture (
      .rst_ni       (rst_ni),
      .we_ni        (we_ni),
      .cle_i        (cle_i),
      .ale_i        (ale_i),
      .io_i         (io_i),
      .byte_o       (cap_byte),
      .toggle_o     (cap_toggle),
      .status_sel_o (status_sel)
   );

   nbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cap_toggle),
      .q_o    (toggle_sync)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) toggle_seen_q <= 1'b0;
      else         toggle_seen_q <= toggle_sync;
   end

   // A toggle change marks a new byte; the payload has been stable since it was captured.
   assign evt_valid = toggle_sync ^ toggle_seen_q;

   nbt_op_ctrl #(
      .ROW_BYTES    (ROW_BYTES),
      .RESET_CYCLES (RESET_CYCLES),
      .ERASE_CYCLES (ERASE_CYCLES)
   ) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .evt_valid_i (evt_valid),
      .evt_i       (cap_byte),
      .busy_o      (busy)
   );

   always_comb begin
      status_byte         = STATUS_FIXED;
      status_byte[RB_BIT] = ~busy;
   end

   assign rb_no   = ~busy;
   assign io_oe_o = status_sel & ~re_ni;
   assign io_o    = io_oe_o ? status_byte : '0;

endmodule

// File: rtl/nbt_checker.sv
module nbt_checker
   import nbt_pkg::*;
#(
   parameter int               RESET_CYCLES = 5000,
   parameter int               ERASE_CYCLES = 300000,
   parameter logic [BUS_W-1:0] STATUS_FIXED = 8'hE0
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             re_ni,
   input logic             rb_no,
   input logic [BUS_W-1:0] io_o,
   input logic             io_oe_o,
   input logic             evt_valid
);

   localparam int MAX_DUR = (RESET_CYCLES > ERASE_CYCLES) ? RESET_CYCLES : ERASE_CYCLES;
   localparam logic [BUS_W-1:0] FIX_MASK = ~(BUS_W'(1) << RB_BIT);

   int unsigned since_evt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       since_evt_q <= 0;
      else if (evt_valid)                since_evt_q <= 0;
      else if (since_evt_q < MAX_DUR + 8) since_evt_q <= since_evt_q + 1;
   end

   p_status_mirror_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      io_oe_o |-> (io_o[RB_BIT] == rb_no));

   p_fixed_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      io_oe_o |-> ((io_o & FIX_MASK) == (STATUS_FIXED & FIX_MASK)));

   p_drive_only_on_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      io_oe_o |-> !re_ni);

   p_busy_needs_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rb_no) |-> $past(evt_valid));

   p_busy_bounded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rb_no |-> (since_evt_q <= MAX_DUR + 2));

endmodule

bind nand_busy_tracker nbt_checker #(
   .RESET_CYCLES (RESET_CYCLES),
   .ERASE_CYCLES (ERASE_CYCLES),
   .STATUS_FIXED (STATUS_FIXED)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .re_ni     (re_ni),
   .rb_no     (rb_no),
   .io_o      (io_o),
   .io_oe_o   (io_oe_o),
   .evt_valid (evt_valid)
);

// File: tb/nand_busy_tracker_tb.sv
module nand_busy_tracker_tb;

   localparam int         RST_C = 40;
   localparam int         ERS_C = 400;
   localparam logic [7:0] FIXED = 8'hE5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       we_n = 1'b1;
   logic       re_n = 1'b1;
   logic       cle = 1'b0;
   logic       ale = 1'b0;
   logic [7:0] io_in = 8'h00;
   logic [7:0] io_out;
   logic       io_oe;
   logic       rb_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int    exp_min[$];
   int    exp_max[$];
   string exp_tag[$];

   always #5 clk = ~clk;

   nand_busy_tracker #(
      .ROW_BYTES    (3),
      .RESET_CYCLES (RST_C),
      .ERASE_CYCLES (ERS_C),
      .SYNC_STAGES  (2),
      .STATUS_FIXED (FIXED)
   ) u_dut (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .we_ni   (we_n),
      .re_ni   (re_n),
      .cle_i   (cle),
      .ale_i   (ale),
      .io_i    (io_in),
      .io_o    (io_out),
      .io_oe_o (io_oe),
      .rb_no   (rb_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // Monitor: measures each low phase of rb_n and compares it with the scoreboard.
   int low_len = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!rb_n) begin
            low_len++;
         end else if (low_len > 0) begin
            if (exp_min.size() == 0) begin
               check(1'b0, "unexpected busy R4/R6/R10", low_len, 0);
            end else begin
               int    lo;
               int    hi;
               string tg;
               lo = exp_min.pop_front();
               hi = exp_max.pop_front();
               tg = exp_tag.pop_front();
               check(low_len >= lo && low_len <= hi, tg, low_len, lo);
            end
            low_len = 0;
         end
      end
   end

   task automatic expect_busy(input int lo, input int hi, input string tag);
      exp_min.push_back(lo);
      exp_max.push_back(hi);
      exp_tag.push_back(tag);
   endtask

   task automatic strobe(input logic c, input logic a, input logic [7:0] v);
      @(negedge clk);
      cle = c; ale = a; io_in = v; we_n = 1'b0;
      #30 we_n = 1'b1;
      #30 cle = 1'b0; ale = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] v);
      strobe(1'b1, 1'b0, v);
   endtask

   task automatic addr(input logic [7:0] v);
      strobe(1'b0, 1'b1, v);
   endtask

   task automatic wait_drain();
      while (exp_min.size() != 0 || !rb_n) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic read_status(output logic [7:0] v, output logic oe);
      @(negedge clk);
      re_n = 1'b0;
      #20 v = io_out; oe = io_oe;
      re_n = 1'b1;
      #10;
   endtask

   task automatic idle_check(input int cycles, input string tag);
      bit stayed = 1'b1;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (!rb_n) stayed = 1'b0;
      end
      check(stayed, tag, stayed, 1);
   endtask

   initial begin
      #2_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [7:0] st;
      logic       oe;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R9: reset state
      check(rb_n === 1'b1, "R9 rb after reset", rb_n, 1);
      check(io_oe === 1'b0, "R9 oe after reset", io_oe, 0);

      // R1: holding the strobe low captures nothing; the rising edge does
      @(negedge clk);
      cle = 1'b1; io_in = 8'hFF; we_n = 1'b0;
      repeat (20) @(negedge clk);
      check(rb_n === 1'b1, "R1 no capture while strobe low", rb_n, 1);
      expect_busy(RST_C, RST_C, "R1 R2 reset length");
      we_n = 1'b1;
      #30 cle = 1'b0;
      wait_drain();

      // R1: both enables high, or neither, is ignored
      strobe(1'b1, 1'b1, 8'hFF);
      strobe(1'b0, 1'b0, 8'hFF);
      idle_check(30, "R1 invalid enables ignored");

      // R2: plain reset
      expect_busy(RST_C, RST_C, "R2 reset length");
      cmd(8'hFF);
      wait_drain();

      // R3: full erase sequence
      cmd(8'h60); addr(8'h12); addr(8'h34);
      addr(8'h01);
      expect_busy(ERS_C, ERS_C, "R3 erase length");
      cmd(8'hD0);
      wait_drain();

      // R4: foreign command mid-sequence aborts
      cmd(8'h60); addr(8'h01); cmd(8'h90); addr(8'h02); addr(8'h03); cmd(8'hD0);
      idle_check(30, "R4 abort by other command");
      // R4: too few address bytes
      cmd(8'h60); addr(8'h01); addr(8'h02); cmd(8'hD0);
      idle_check(30, "R4 short address");
      // R4: extra address byte
      cmd(8'h60); addr(8'h01); addr(8'h02); addr(8'h03); addr(8'h04); cmd(8'hD0);
      idle_check(30, "R4 extra address");
      // R4: repeated setup restarts the sequence
      cmd(8'h60); addr(8'h01); cmd(8'h60); addr(8'h05); addr(8'h06); addr(8'h07);
      expect_busy(ERS_C, ERS_C, "R4 restart then erase");
      cmd(8'hD0);
      wait_drain();

      // R10: stray address bytes while idle, then confirm
      addr(8'h11); addr(8'h22); addr(8'h33); cmd(8'hD0);
      idle_check(30, "R10 stray address ignored");

      // R6 and R7/R8: erase busy, another erase sequence ignored, status read while busy
      cmd(8'h60); addr(8'h01); addr(8'h02); addr(8'h03);
      expect_busy(ERS_C, ERS_C, "R6 erase not extended");
      cmd(8'hD0);
      repeat (20) @(negedge clk);
      cmd(8'h60); addr(8'h0A); addr(8'h0B); addr(8'h0C); cmd(8'hD0);
      cmd(8'h70);
      read_status(st, oe);
      check(oe === 1'b1, "R7 oe during read", oe, 1);
      check(st === 8'hA5, "R8 status while busy", st, 8'hA5);
      check(io_oe === 1'b0, "R7 oe released with re high", io_oe, 0);
      wait_drain();
      cmd(8'hD0);
      idle_check(30, "R6 no pending erase left");

      // R7/R8: status while ready, then closed by another command
      cmd(8'h70);
      read_status(st, oe);
      check(oe === 1'b1, "R7 oe while ready", oe, 1);
      check(st === 8'hE5, "R8 status while ready", st, 8'hE5);
      cmd(8'h90);
      read_status(st, oe);
      check(oe === 1'b0, "R7 status mode closed", oe, 0);

      // R5: reset cuts an erase short
      cmd(8'h60); addr(8'h01); addr(8'h02); addr(8'h03);
      expect_busy(80, 120, "R5 reset aborts erase");
      cmd(8'hD0);
      repeat (50) @(negedge clk);
      cmd(8'hFF);
      wait_drain();
      check(exp_min.size() == 0, "R5 scoreboard drained", exp_min.size(), 0);

      report();
   end

endmodule